// File: doc/BRIEF.md
# Address Table Command Engine

This block is a register-driven command engine sitting in front of a small MAC address table inside a multi-port Ethernet switch. Host software fills in a database number, a 48-bit MAC spread over three 16-bit registers, and a data word holding an entry state, a trunk flag and a port vector. It then writes an operation word with its go/busy bit set. The engine walks the whole table, one slot per clock cycle, and carries out one of three command families: load/purge of a single entry, get-next iteration in ascending MAC order, and flush/move over a group of entries.

The data word decides between flush and move. A zero state flushes the entries it selects. State 0xF turns the same command into a port move: the low field of the port vector names the source port and the next field names the destination. The host polls the busy bit, which it reads back in the operation register, and waits for it to clear before it issues the next command or reads any results.

Top module: `addr_cmd_engine`

## Requirements
- R1: After reset every register reads zero, busy is clear and the table is empty. A get-next issued at that point returns state 0.
- R2: The MAC is held in registers 3, 4 and 5. Byte 0, the most significant byte for ordering, is in register 3 bits 15:8. Byte 1 is in register 3 bits 7:0, and so on through byte 5 in register 5 bits 7:0. Every register reads back the value last written to it.
- R3: Writing register 1 (operation) with bit 15 set while idle starts the command held in bits 14:12. Register 1 bit 15 then reads 1 until the command completes, and the command completes within DEPTH+2 cycles.
- R4: While busy, host writes to any register are ignored. This includes a second operation write, which neither starts a command nor changes the stored operation word.
- R5: With 64 databases, database bits 3:0 come from operation bits 3:0 and database bits 5:4 come from operation bits 9:8. Databases 0x01 and 0x21 are therefore distinct.
- R6: Load (code 3) stores the entry formed from the MAC registers and register 2 (state in bits 3:0, port vector in bits 11:4, trunk in bit 15) into the selected database. An existing entry with the same database and MAC is overwritten. When the table is full, a new key is dropped.
- R7: Load with state 0 removes the entry that matches the database and MAC, and leaves all other entries in place.
- R8: Get-next (code 4) returns the valid entry of the selected database with the smallest MAC above the MAC registers, or the smallest MAC overall when the MAC registers hold all ones. The result is written into register 2 and the MAC registers. When no such entry exists, register 2 becomes 0 and the MAC becomes all ones.
- R9: Get-next never returns an entry that belongs to another database.
- R10: When the data state is 0, the flush codes remove entries: code 1 removes every entry, code 2 every non-static entry, code 5 every entry of the selected database, and code 6 every non-static entry of that database.
- R11: States 0xE and 0xF are static. Codes 2 and 6 leave static entries untouched for both flush and move.
- R12: When the data state is 0xF, the same codes move ports instead. Entries in scope that contain the source port (data bits 7:4) have that port cleared and the destination port (data bits 11:8) set. A destination of 0xF only clears the source port. An entry left with an empty port vector becomes invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address: 0 control, 1 operation, 2 data, 3..5 MAC, 6 database |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr`, available in the same cycle |

## Verification
The hardest state to reach from the ports is a full table that receives one more new key, combined with a move that empties an entry's port vector. The bench first loads entries until all slots are taken, then loads a further key and confirms it is absent by walking every database with get-next. Later it issues a remove move against an entry whose only port is the source port and checks that the walk no longer returns that entry. Throughout, a bench-side table model predicts every get-next result arithmetically.

// File: rtl/ace_pkg.sv
package ace_pkg;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_OP   = 3'd1;
  localparam logic [2:0] A_DATA = 3'd2;
  localparam logic [2:0] A_MAC0 = 3'd3;
  localparam logic [2:0] A_MAC1 = 3'd4;
  localparam logic [2:0] A_MAC2 = 3'd5;
  localparam logic [2:0] A_DB   = 3'd6;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_FM_ALL   = 3'd1,
    OP_FM_NS    = 3'd2,
    OP_LOAD     = 3'd3,
    OP_NEXT     = 3'd4,
    OP_FM_ALLDB = 3'd5,
    OP_FM_NSDB  = 3'd6,
    OP_RSVD     = 3'd7
  } aceOp_e;

  typedef struct packed {
    logic start;
    logic step;
    logic finish;
  } aceStb_t;
endpackage

// File: rtl/ace_ctrl.sv
module ace_ctrl
  import ace_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic             goBit,
  output logic             busy,
  output aceStb_t          stb,
  output logic [IDX_W-1:0] idx
);
  typedef enum logic [1:0] {S_IDLE, S_WALK, S_DONE} state_e;
  state_e state;
  logic accept;

  assign accept = wrEn && (addr == A_OP) && goBit && (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state <= S_WALK;
          idx   <= '0;
        end
        S_WALK: if (idx == IDX_W'(DEPTH - 1)) state <= S_DONE;
                else idx <= idx + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.start  = accept;
    stb.step   = (state == S_WALK);
    stb.finish = (state == S_DONE);
    busy       = (state != S_IDLE);
  end
endmodule

// File: rtl/ace_datapath.sv
module ace_datapath
  import ace_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NUM_DB = 64,
  parameter int PORTS  = 8,
  parameter int MOVE_W = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int DB_W  = (NUM_DB <= 2) ? 1 : $clog2(NUM_DB)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [15:0]      wrData,
  input  logic             busy,
  input  aceStb_t          stb,
  input  logic [IDX_W-1:0] idx,
  output logic [15:0]      rdData
);
  logic [15:0] ctrlR, dataR;
  logic [14:0] opR;
  logic [47:0] macR;
  logic [11:0] dbR, dbWide;
  aceOp_e      cmdOp;
  logic [DB_W-1:0] cmdDb;

  logic [3:0]       tState [DEPTH];
  logic             tTrunk [DEPTH];
  logic [PORTS-1:0] tPvec  [DEPTH];
  logic [DB_W-1:0]  tDb    [DEPTH];
  logic [47:0]      tMac   [DEPTH];

  logic matchFound, freeFound, bestFound;
  logic [IDX_W-1:0] matchIdx, freeIdx, bestIdx;
  logic [47:0] bestMac;

  // database number placement depends on how many databases exist
  generate
    if (NUM_DB <= 16) begin : g_db16
      assign dbWide = {8'd0, wrData[3:0]};
    end else if (NUM_DB <= 64) begin : g_db64
      assign dbWide = {6'd0, wrData[9:8], wrData[3:0]};
    end else if (NUM_DB <= 256) begin : g_db256
      assign dbWide = {4'd0, ctrlR[15:12], wrData[3:0]};
    end else begin : g_dbreg
      assign dbWide = dbR;
    end
  endgenerate

  logic [3:0]        dState, curState;
  logic [PORTS-1:0]  dPvec, curPvec, fromBit, toBit, movedVec, one;
  logic [MOVE_W-1:0] fromP, toP;
  logic [47:0]       curMac;
  logic hit, dbHit, macHit, isFlush, inScope, nsOnly, allDb, eligible, moveHit;

  always_comb begin
    dState   = dataR[3:0];
    dPvec    = dataR[4 +: PORTS];
    fromP    = dataR[4 +: MOVE_W];
    toP      = dataR[4 + MOVE_W +: MOVE_W];
    one      = {{(PORTS-1){1'b0}}, 1'b1};
    curState = tState[idx];
    curPvec  = tPvec[idx];
    curMac   = tMac[idx];
    hit      = curState != 4'd0;
    dbHit    = tDb[idx] == cmdDb;
    macHit   = curMac == macR;
    allDb    = (cmdOp == OP_FM_ALL) || (cmdOp == OP_FM_NS);
    nsOnly   = (cmdOp == OP_FM_NS) || (cmdOp == OP_FM_NSDB);
    isFlush  = allDb || (cmdOp == OP_FM_ALLDB) || (cmdOp == OP_FM_NSDB);
    inScope  = allDb || dbHit;
    eligible = hit && isFlush && inScope && !(nsOnly && curState >= 4'hE);
    fromBit  = one << fromP;
    toBit    = (toP == {MOVE_W{1'b1}}) ? '0 : (one << toP);
    moveHit  = (curPvec & fromBit) != '0;
    movedVec = (curPvec & ~fromBit) | toBit;
  end

  // host register file and get-next result write-back
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlR <= '0; opR <= '0; dataR <= '0; macR <= '0; dbR <= '0;
      cmdOp <= OP_NOP; cmdDb <= '0;
    end else begin
      if (wrEn && !busy) begin
        case (addr)
          A_CTRL: ctrlR <= wrData;
          A_OP:   opR <= wrData[14:0];
          A_DATA: dataR <= wrData;
          A_MAC0: macR[47:32] <= wrData;
          A_MAC1: macR[31:16] <= wrData;
          A_MAC2: macR[15:0] <= wrData;
          A_DB:   dbR <= wrData[11:0];
          default: ;
        endcase
      end
      if (stb.start) begin
        cmdOp <= aceOp_e'(wrData[14:12]);
        cmdDb <= dbWide[DB_W-1:0];
      end
      if (stb.finish && cmdOp == OP_NEXT) begin
        if (bestFound) begin
          dataR <= '0;
          dataR[3:0] <= tState[bestIdx];
          dataR[4 +: PORTS] <= tPvec[bestIdx];
          dataR[15] <= tTrunk[bestIdx];
          macR <= bestMac;
        end else begin
          dataR <= '0;
          macR <= '1;
        end
      end
    end
  end

  // table storage and the slot-by-slot walk
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        tState[i] <= '0; tTrunk[i] <= 1'b0; tPvec[i] <= '0;
        tDb[i] <= '0; tMac[i] <= '0;
      end
      matchFound <= 1'b0; freeFound <= 1'b0; bestFound <= 1'b0;
      matchIdx <= '0; freeIdx <= '0; bestIdx <= '0; bestMac <= '0;
    end else begin
      if (stb.start) begin
        matchFound <= 1'b0; freeFound <= 1'b0; bestFound <= 1'b0;
      end
      if (stb.step) begin
        if (hit && dbHit && macHit && !matchFound) begin
          matchFound <= 1'b1; matchIdx <= idx;
        end
        if (!hit && !freeFound) begin
          freeFound <= 1'b1; freeIdx <= idx;
        end
        if (cmdOp == OP_NEXT && hit && dbHit && ((&macR) || curMac > macR) &&
            (!bestFound || curMac < bestMac)) begin
          bestFound <= 1'b1; bestIdx <= idx; bestMac <= curMac;
        end
        if (eligible) begin
          if (dState == 4'd0) tState[idx] <= 4'd0;
          else if (dState == 4'hF && moveHit) begin
            tPvec[idx] <= movedVec;
            if (movedVec == '0) tState[idx] <= 4'd0;
          end
        end
      end
      if (stb.finish && cmdOp == OP_LOAD) begin
        if (dState == 4'd0) begin
          if (matchFound) tState[matchIdx] <= 4'd0;
        end else if (matchFound || freeFound) begin
          tState[matchFound ? matchIdx : freeIdx] <= dState;
          tTrunk[matchFound ? matchIdx : freeIdx] <= dataR[15];
          tPvec[matchFound ? matchIdx : freeIdx]  <= dPvec;
          tDb[matchFound ? matchIdx : freeIdx]    <= cmdDb;
          tMac[matchFound ? matchIdx : freeIdx]   <= macR;
        end
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL: rdData = ctrlR;
      A_OP:   rdData = {busy, opR};
      A_DATA: rdData = dataR;
      A_MAC0: rdData = macR[47:32];
      A_MAC1: rdData = macR[31:16];
      A_MAC2: rdData = macR[15:0];
      A_DB:   rdData = {4'd0, dbR};
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/addr_cmd_engine.sv
module addr_cmd_engine
  import ace_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int NUM_DB = 64,
  parameter int PORTS  = 8,
  parameter int MOVE_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData
);
  logic busy;
  aceStb_t stb;
  logic [IDX_W-1:0] idx;

  ace_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .goBit(wrData[15]),
    .busy(busy), .stb(stb), .idx(idx)
  );

  ace_datapath #(.DEPTH(DEPTH), .NUM_DB(NUM_DB), .PORTS(PORTS), .MOVE_W(MOVE_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .busy(busy), .stb(stb), .idx(idx), .rdData(rdData)
  );
endmodule

// File: rtl/ace_checker.sv
module ace_checker
  import ace_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 4) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [2:0]       addr,
  input logic             goBit,
  input logic [15:0]      rdData,
  input logic             busy,
  input aceStb_t          stb,
  input logic [IDX_W-1:0] idx
);
  logic [CNT_W-1:0] busyCnt;
  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= '0;
    else busyCnt <= busy ? busyCnt + 1'b1 : '0;
  end

  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_OP && goBit && !busy) |=> busy);
  a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt <= CNT_W'(DEPTH)));
  a_r3_finish_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> !busy);
  a_r3_busy_visible: assert property (@(posedge clk) disable iff (!rstN)
    (addr == A_OP) |-> (rdData[15] == busy));
  a_r4_write_keeps_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.finish && wrEn && addr == A_OP) |=> busy);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.start, stb.step, stb.finish}));
  a_r3_walk_order: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && $past(stb.step)) |-> (idx == $past(idx) + 1'b1));
endmodule

bind addr_cmd_engine ace_checker #(.DEPTH(DEPTH)) u_ace_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .goBit(wrData[15]),
  .rdData(rdData), .busy(busy), .stb(stb), .idx(idx)
);

// File: tb/addr_cmd_engine_bench.sv
module addr_cmd_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] rdData;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // table model
  bit          mV  [DEPTH];
  int          mDb [DEPTH];
  logic [47:0] mMac[DEPTH];
  logic [3:0]  mSt [DEPTH];
  bit          mTr [DEPTH];
  logic [7:0]  mPv [DEPTH];

  addr_cmd_engine u_addr_cmd_engine (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdData;
  endtask

  task automatic waitIdle(output int cyc);
    logic [15:0] v;
    cyc = 0;
    rd(3'd1, v);
    while (v[15] && cyc < 1000) begin
      cyc++;
      rd(3'd1, v);
    end
  endtask

  function automatic logic [15:0] opWord(input int code, input int db);
    return 16'h8000 | 16'((code & 7) << 12) | 16'(((db >> 4) & 3) << 8) | 16'(db & 15);
  endfunction

  function automatic logic [47:0] macOf(input int i);
    return {8'(i * 53 + 7), 8'(i * 29), 16'hA5A5, 8'(i), 8'(255 - i * 17)};
  endfunction

  task automatic setMac(input logic [47:0] m);
    wr(3'd3, m[47:32]); wr(3'd4, m[31:16]); wr(3'd5, m[15:0]);
  endtask

  task automatic runCmd(input int code, input int db);
    int c;
    wr(3'd1, opWord(code, db));
    waitIdle(c);
    check(c <= DEPTH + 2, "R3 completion time", 64'(c), 64'(DEPTH + 2));
  endtask

  task automatic mLoad(input int db, input logic [47:0] m, input logic [3:0] st,
                       input bit tr, input logic [7:0] pv);
    int hitI = -1, freeI = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (mV[i] && mDb[i] == db && mMac[i] == m && hitI < 0) hitI = i;
      if (!mV[i] && freeI < 0) freeI = i;
    end
    if (st == 4'd0) begin
      if (hitI >= 0) mV[hitI] = 1'b0;
    end else begin
      int w;
      w = (hitI >= 0) ? hitI : freeI;
      if (w >= 0) begin
        mV[w] = 1'b1; mDb[w] = db; mMac[w] = m; mSt[w] = st; mTr[w] = tr; mPv[w] = pv;
      end
    end
  endtask

  task automatic doLoad(input int db, input logic [47:0] m, input logic [3:0] st,
                        input bit tr, input logic [7:0] pv);
    setMac(m);
    wr(3'd2, {tr, 3'b000, pv, st});
    runCmd(3, db);
    mLoad(db, m, st, tr, pv);
  endtask

  task automatic mFlushMove(input int code, input int db, input logic [15:0] d);
    logic [7:0] fromB, toB, nv;
    fromB = (d[7:4] < 8) ? 8'(1 << d[7:4]) : 8'd0;
    toB   = (d[11:8] < 8) ? 8'(1 << d[11:8]) : 8'd0;
    for (int i = 0; i < DEPTH; i++) begin
      bit scope, ns;
      scope = (code == 1 || code == 2) ? 1'b1 : (mDb[i] == db);
      ns    = (code == 2 || code == 6);
      if (mV[i] && scope && !(ns && mSt[i] >= 4'hE)) begin
        if (d[3:0] == 4'd0) mV[i] = 1'b0;
        else if (d[3:0] == 4'hF && (mPv[i] & fromB) != 0) begin
          nv = (mPv[i] & ~fromB) | toB;
          mPv[i] = nv;
          if (nv == 0) mV[i] = 1'b0;
        end
      end
    end
  endtask

  task automatic doFlushMove(input int code, input int db, input logic [15:0] d, input string req);
    wr(3'd2, d);
    runCmd(code, db);
    mFlushMove(code, db, d);
    $display("note: %s command issued", req);
  endtask

  // walk one database with get-next and compare to the model
  task automatic walkDb(input int db, input string req);
    logic [47:0] prev, got;
    logic [15:0] d, m0, m1, m2;
    bit done;
    setMac(48'hFFFF_FFFF_FFFF);
    prev = 48'hFFFF_FFFF_FFFF;
    done = 1'b0;
    for (int k = 0; k < DEPTH + 2 && !done; k++) begin
      int best;
      best = -1;
      runCmd(4, db);
      rd(3'd2, d); rd(3'd3, m0); rd(3'd4, m1); rd(3'd5, m2);
      got = {m0, m1, m2};
      for (int i = 0; i < DEPTH; i++)
        if (mV[i] && mDb[i] == db && (prev == 48'hFFFF_FFFF_FFFF || mMac[i] > prev) &&
            (best < 0 || mMac[i] < mMac[best])) best = i;
      if (best >= 0) begin
        check(d == {mTr[best], 3'b000, mPv[best], mSt[best]}, {req, " R8 data"},
              64'(d), 64'({mTr[best], 3'b000, mPv[best], mSt[best]}));
        check(got == mMac[best], {req, " R2 R8 mac"}, 64'(got), 64'(mMac[best]));
      end else begin
        check(d == 16'd0, {req, " R8 end data"}, 64'(d), 64'd0);
        check(got == 48'hFFFF_FFFF_FFFF, {req, " R8 end mac"}, 64'(got), 64'hFFFF_FFFF_FFFF);
        done = 1'b1;
      end
      prev = got;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] v;
    int c;
    for (int i = 0; i < DEPTH; i++) mV[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of every register
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check(v == 16'd0, "R1 reset register", 64'(v), 64'd0);
    end
    walkDb(1, "R1 empty table");

    // R2: register readback
    wr(3'd0, 16'h3C5A); rd(3'd0, v); check(v == 16'h3C5A, "R2 ctrl readback", 64'(v), 64'h3C5A);
    wr(3'd6, 16'h0ABC); rd(3'd6, v); check(v == 16'h0ABC, "R2 db readback", 64'(v), 64'h0ABC);
    setMac(48'h0102_0304_0506);
    rd(3'd3, v); check(v == 16'h0102, "R2 mac0 readback", 64'(v), 64'h0102);
    rd(3'd5, v); check(v == 16'h0506, "R2 mac2 readback", 64'(v), 64'h0506);
    wr(3'd0, 16'h0000);

    // R6 R5 R9: loads in databases 0x01, 0x21, 0x05
    for (int i = 0; i < 10; i++) begin
      int db;
      db = (i % 3 == 0) ? 1 : ((i % 3 == 1) ? 33 : 5);
      doLoad(db, macOf(i), (i % 4 == 0) ? 4'hE : 4'(1 + i % 7), i[0], 8'(1 << (i % 8)) | 8'h04);
    end
    // byte 0 ordering: byte 0 smaller but lower bytes larger
    doLoad(1, 48'h00FF_FFFF_FFFF, 4'h7, 1'b0, 8'h20);
    doLoad(1, 48'h0100_0000_0000, 4'h7, 1'b1, 8'h24);
    walkDb(1, "R5 R9 db01");
    walkDb(33, "R5 R9 db21");
    walkDb(5, "R9 db05");

    // R6 overwrite and R7 purge
    doLoad(33, macOf(1), 4'h3, 1'b1, 8'h81);
    walkDb(33, "R6 overwrite");
    doLoad(1, macOf(3), 4'h0, 1'b0, 8'h00);
    walkDb(1, "R7 purge");

    // R6 full table: fill, then one more new key is dropped
    for (int i = 20; i < 40; i++) doLoad(5, macOf(i), 4'h5, 1'b0, 8'h10);
    walkDb(5, "R6 full db05");
    walkDb(1, "R6 full db01");
    walkDb(33, "R6 full db21");

    // R3 R4: busy visibility and ignored writes while busy
    wr(3'd2, 16'h0777);
    @(negedge clk); wrEn = 1'b1; addr = 3'd1; wrData = 16'h8000;
    @(negedge clk); wrEn = 1'b0; #1;
    check(rdData[15] == 1'b1, "R3 busy set", 64'(rdData), 64'h8000);
    wr(3'd2, 16'h1234);
    wr(3'd1, opWord(1, 0));
    wr(3'd3, 16'hDEAD);
    waitIdle(c);
    rd(3'd2, v); check(v == 16'h0777, "R4 data write ignored", 64'(v), 64'h0777);
    rd(3'd1, v); check(v == 16'h0000, "R4 op write ignored", 64'(v), 64'h0000);
    walkDb(5, "R4 no flush started");

    // R12 move: port 2 to port 5 inside db 0x21, then remove port 2 everywhere
    doFlushMove(5, 33, 16'h052F, "R12 move");
    walkDb(33, "R12 moved");
    walkDb(1, "R12 other db untouched");
    doFlushMove(1, 0, 16'h0F2F, "R12 remove");
    walkDb(1, "R12 removed db01");
    walkDb(5, "R12 removed db05");
    walkDb(33, "R12 removed db21");

    // R11 R10 flush variants
    doFlushMove(6, 5, 16'h0000, "R11 ns db flush");
    walkDb(5, "R11 db05 statics stay");
    doFlushMove(2, 0, 16'h0000, "R11 ns flush");
    walkDb(1, "R11 db01 statics stay");
    walkDb(33, "R11 db21 statics stay");
    doLoad(5, macOf(50), 4'h6, 1'b0, 8'h01);
    doLoad(1, macOf(51), 4'h6, 1'b0, 8'h02);
    doFlushMove(5, 1, 16'h0000, "R10 db flush");
    walkDb(1, "R10 db01 empty");
    walkDb(5, "R10 db05 kept");
    doFlushMove(1, 0, 16'h0000, "R10 all flush");
    walkDb(5, "R10 all empty db05");
    walkDb(33, "R10 all empty db21");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule